// File: doc/BRIEF.md
# Time-Delay-Integration Pixel Accumulator

This block is the digital core of a scanned-array readout that integrates each object element as it moves past a stack of sensor rows. The array has `NSTAGE` rows along the scan direction and `NCOL` columns across it. Every line period the whole array is sampled once. Each column-and-stage position holds a running partial sum that steps one stage down the scan direction per line and adds the pixel value found there. When an element's sum has passed through all `NSTAGE` stages, the full sum is emitted and that position starts again from nothing. Line follows line with no gaps, so in steady state every column yields one integrated result per line.

Samples arrive as a serial pixel stream, one per beat. Within a line the beats visit column 0 stages 0 to `NSTAGE-1`, then column 1, and so on. A start-of-line flag marks the first beat. A mode input, taken only at that first beat, selects integration or staring readout. In staring mode every pixel is passed straight to the output with its column and row, and nothing is integrated. Integrated sums saturate instead of wrapping, and an overflow flag goes out with the saturated result. After reset, and after any change of mode, the integration pipeline restarts empty. Outputs are held back until a full stack of stages has been refilled.

Top module: `tdi_accum`

## Requirements
- R1: A beat is a cycle with `pix_valid` high. `pix_sol` high marks the beat for column 0, stage 0. Within a line, beats run through stages 0 to NSTAGE-1 of each column, with the columns in ascending order. Beats between reset and the first `pix_sol` beat are ignored and produce no output.
- R2: In integration mode (`mode_sel`=0), the stage NSTAGE-1 beat of column c in line L produces an output in the following cycle. Its value is the sum over s of the stage-s sample of column c taken in line L-(NSTAGE-1-s).
- R3: An integrated sum above 2^OUT_W-1 is output as all ones with `out_ovf`=1. A sum of exactly 2^OUT_W-1 is output with `out_ovf`=0.
- R4: In integration mode there is exactly one valid output per column per line, in ascending column order. `out_col` is the column, `out_row` is NSTAGE-1 and `out_stare` is 0.
- R5: After reset, or after a line that starts in a different mode than the previous line, the integrated outputs of the first NSTAGE-1 lines are not valid. The outputs of the NSTAGE-th line contain no sample taken before the restart.
- R6: In staring mode (`mode_sel`=1), every beat produces a valid output in the following cycle. The output carries the sample zero-extended, `out_col` and `out_row` equal to the beat's column and stage, `out_stare`=1 and `out_ovf`=0.
- R7: `mode_sel` is sampled only on `pix_sol` beats. A change on any other beat has no effect on that line.
- R8: While reset is asserted, `out_valid`, `out_ovf` and `out_data` are 0. A cycle with `pix_valid` low produces no output, and idle cycles inside a line leave the integration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Beat strobe: one pixel sample present |
| pix_sol | input | 1 | Marks the first beat of a line (column 0, stage 0) |
| mode_sel | input | 1 | 0 = integration, 1 = staring; sampled at `pix_sol` |
| pix_data | input | IN_W | Pixel sample |
| out_valid | output | 1 | Output word present |
| out_stare | output | 1 | Output word is a staring-mode pixel |
| out_col | output | $clog2(NCOL) | Column of the output word |
| out_row | output | $clog2(NSTAGE) | Stage of the output word |
| out_data | output | OUT_W | Integrated sum or raw pixel |
| out_ovf | output | 1 | Sum saturated |

## Verification
A ramp pattern makes every column, stage and line carry a different value. A hashed pattern with stage-dependent high bits exposes a sum that takes a stage from the wrong line or the wrong column. Two near-full patterns, one totalling exactly full scale and one totalling one above it, separate a correct clamp from an off-by-one clamp. After a saturated run, an all-zero run in integration mode shows whether stale partial sums survive the flush. Staring runs with maximum samples, `mode_sel` toggled mid-line, and idle gaps inside lines show that mode sampling, pass-through and stalls do not disturb the integration.

// File: rtl/tdi_pkg.sv
package tdi_pkg;

  typedef enum logic {
    MODE_TDI   = 1'b0,
    MODE_STARE = 1'b1
  } tdi_mode_e;

  // Per-beat control produced by the sequencer
  typedef struct packed {
    logic beat;     // accepted sample this cycle
    logic stare;    // line runs in staring mode
    logic emit_ok;  // last stage of a fully refilled integration line
  } beat_ctl_t;

endpackage

// File: rtl/tdi_seq.sv
module tdi_seq
  import tdi_pkg::*;
#(
  parameter int NSTAGE = 8,
  parameter int NCOL   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_valid,
  input  logic                      pix_sol,
  input  logic                      mode_sel,
  output beat_ctl_t                 ctl,
  output logic [$clog2(NSTAGE)-1:0] cur_stage,
  output logic [$clog2(NCOL)-1:0]   cur_col,
  output logic [$clog2(NSTAGE)-1:0] cur_fill
);

  localparam int SW = $clog2(NSTAGE);
  localparam int CW = $clog2(NCOL);
  localparam logic [SW-1:0] LAST_STAGE = SW'(NSTAGE - 1);
  localparam logic [CW-1:0] LAST_COL   = CW'(NCOL - 1);

  logic          started_q, started_d;
  logic [SW-1:0] stage_q, stage_d;
  logic [CW-1:0] col_q, col_d;
  logic [SW-1:0] fill_q, fill_d;
  tdi_mode_e     mode_q, mode_d;
  tdi_mode_e     cur_mode;
  logic          beat;
  logic          restart;
  logic          state_en;

  // Current-beat view: a start-of-line beat overrides the stored position
  always_comb begin
    beat      = pix_valid && (pix_sol || started_q);
    cur_stage = pix_sol ? '0 : stage_q;
    cur_col   = pix_sol ? '0 : col_q;
    cur_mode  = pix_sol ? tdi_mode_e'(mode_sel) : mode_q;
    restart   = pix_sol && (!started_q || (tdi_mode_e'(mode_sel) != mode_q));
    if (restart) begin
      cur_fill = '0;
    end else if (pix_sol && (fill_q != LAST_STAGE)) begin
      cur_fill = fill_q + SW'(1);
    end else begin
      cur_fill = fill_q;
    end
  end

  // Next-state of the position counters
  always_comb begin
    state_en  = beat;
    started_d = 1'b1;
    mode_d    = cur_mode;
    fill_d    = cur_fill;
    if (cur_stage == LAST_STAGE) begin
      stage_d = '0;
      col_d   = (cur_col == LAST_COL) ? '0 : cur_col + CW'(1);
    end else begin
      stage_d = cur_stage + SW'(1);
      col_d   = cur_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      stage_q   <= '0;
      col_q     <= '0;
      fill_q    <= '0;
      mode_q    <= MODE_TDI;
    end else if (state_en) begin
      started_q <= started_d;
      stage_q   <= stage_d;
      col_q     <= col_d;
      fill_q    <= fill_d;
      mode_q    <= mode_d;
    end
  end

  always_comb begin
    ctl.beat    = beat;
    ctl.stare   = (cur_mode == MODE_STARE);
    ctl.emit_ok = beat && (cur_mode == MODE_TDI) &&
                  (cur_stage == LAST_STAGE) && (cur_fill == LAST_STAGE);
  end

endmodule

// File: rtl/tdi_acc_bank.sv
module tdi_acc_bank #(
  parameter int NSTAGE = 8,
  parameter int NCOL   = 4,
  parameter int IN_W   = 14,
  parameter int OUT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat,
  input  logic                      stare,
  input  logic [$clog2(NSTAGE)-1:0] stage,
  input  logic [$clog2(NCOL)-1:0]   col,
  input  logic [$clog2(NSTAGE)-1:0] fill,
  input  logic [IN_W-1:0]           sample,
  output logic [OUT_W-1:0]          sum,
  output logic                      sum_ovf
);

  localparam int SW    = $clog2(NSTAGE);
  localparam int CW    = $clog2(NCOL);
  localparam int NPART = NSTAGE - 1;
  localparam logic [SW-1:0] LAST_STAGE = SW'(NSTAGE - 1);

  // Partial sums for stages 0..NSTAGE-2; the last stage goes straight out
  logic [OUT_W-1:0] part_q [NPART][NCOL];
  logic             povf_q [NPART][NCOL];
  logic             wr_hit [NPART][NCOL];

  logic [OUT_W-1:0] carry_q;
  logic             carry_ovf_q;
  logic [OUT_W-1:0] rd_val;
  logic             rd_ovf;
  logic [OUT_W-1:0] prev_val;
  logic             prev_ovf;
  logic [OUT_W:0]   wide;
  logic             clip;
  logic             upd_en;

  // Only links written since the last restart feed the next stage
  always_comb begin
    upd_en   = beat && !stare && (stage != LAST_STAGE);
    if ((stage != '0) && (stage <= fill)) begin
      prev_val = carry_q;
      prev_ovf = carry_ovf_q;
    end else begin
      prev_val = '0;
      prev_ovf = 1'b0;
    end
    wide    = {1'b0, prev_val} + (OUT_W+1)'(sample);
    clip    = wide[OUT_W];
    sum     = clip ? '1 : wide[OUT_W-1:0];
    sum_ovf = prev_ovf | clip;
  end

  // Read the value about to be overwritten, for use at the next stage
  always_comb begin
    rd_val = '0;
    rd_ovf = 1'b0;
    for (int g = 0; g < NPART; g++) begin
      for (int k = 0; k < NCOL; k++) begin
        if ((stage == SW'(g)) && (col == CW'(k))) begin
          rd_val = part_q[g][k];
          rd_ovf = povf_q[g][k];
        end
      end
    end
  end

  for (genvar g = 0; g < NPART; g++) begin : g_stage
    for (genvar k = 0; k < NCOL; k++) begin : g_col
      assign wr_hit[g][k] = upd_en && (stage == SW'(g)) && (col == CW'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NPART; g++) begin
        for (int k = 0; k < NCOL; k++) begin
          part_q[g][k] <= '0;
          povf_q[g][k] <= 1'b0;
        end
      end
    end else begin
      for (int g = 0; g < NPART; g++) begin
        for (int k = 0; k < NCOL; k++) begin
          if (wr_hit[g][k]) begin
            part_q[g][k] <= sum;
            povf_q[g][k] <= sum_ovf;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q     <= '0;
      carry_ovf_q <= 1'b0;
    end else if (upd_en) begin
      carry_q     <= rd_val;
      carry_ovf_q <= rd_ovf;
    end
  end

endmodule

// File: rtl/tdi_out_mux.sv
module tdi_out_mux #(
  parameter int NSTAGE = 8,
  parameter int NCOL   = 4,
  parameter int IN_W   = 14,
  parameter int OUT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat,
  input  logic                      stare,
  input  logic                      emit_ok,
  input  logic [OUT_W-1:0]          sum,
  input  logic                      sum_ovf,
  input  logic [IN_W-1:0]           sample,
  input  logic [$clog2(NSTAGE)-1:0] stage,
  input  logic [$clog2(NCOL)-1:0]   col,
  output logic                      out_valid,
  output logic                      out_stare,
  output logic [$clog2(NCOL)-1:0]   out_col,
  output logic [$clog2(NSTAGE)-1:0] out_row,
  output logic [OUT_W-1:0]          out_data,
  output logic                      out_ovf
);

  localparam int SW = $clog2(NSTAGE);
  localparam int CW = $clog2(NCOL);

  logic             valid_d;
  logic             word_en;
  logic [OUT_W-1:0] data_d;
  logic             ovf_d;

  always_comb begin
    valid_d = beat && (stare || emit_ok);
    word_en = valid_d;
    data_d  = stare ? OUT_W'(sample) : sum;
    ovf_d   = !stare && sum_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stare <= 1'b0;
      out_col   <= '0;
      out_row   <= '0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else if (word_en) begin
      out_stare <= stare;
      out_col   <= col;
      out_row   <= stage;
      out_data  <= data_d;
      out_ovf   <= ovf_d;
    end
  end

endmodule

// File: rtl/tdi_accum.sv
module tdi_accum
  import tdi_pkg::*;
#(
  parameter int NSTAGE = 8,
  parameter int NCOL   = 4,
  parameter int IN_W   = 14,
  parameter int OUT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_valid,
  input  logic                      pix_sol,
  input  logic                      mode_sel,
  input  logic [IN_W-1:0]           pix_data,
  output logic                      out_valid,
  output logic                      out_stare,
  output logic [$clog2(NCOL)-1:0]   out_col,
  output logic [$clog2(NSTAGE)-1:0] out_row,
  output logic [OUT_W-1:0]          out_data,
  output logic                      out_ovf
);

  localparam int SW = $clog2(NSTAGE);
  localparam int CW = $clog2(NCOL);

  beat_ctl_t        ctl;
  logic [SW-1:0]    cur_stage;
  logic [CW-1:0]    cur_col;
  logic [SW-1:0]    cur_fill;
  logic [OUT_W-1:0] sum;
  logic             sum_ovf;

  tdi_seq #(.NSTAGE(NSTAGE), .NCOL(NCOL)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_sol   (pix_sol),
    .mode_sel  (mode_sel),
    .ctl       (ctl),
    .cur_stage (cur_stage),
    .cur_col   (cur_col),
    .cur_fill  (cur_fill)
  );

  tdi_acc_bank #(.NSTAGE(NSTAGE), .NCOL(NCOL), .IN_W(IN_W), .OUT_W(OUT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (ctl.beat),
    .stare   (ctl.stare),
    .stage   (cur_stage),
    .col     (cur_col),
    .fill    (cur_fill),
    .sample  (pix_data),
    .sum     (sum),
    .sum_ovf (sum_ovf)
  );

  tdi_out_mux #(.NSTAGE(NSTAGE), .NCOL(NCOL), .IN_W(IN_W), .OUT_W(OUT_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (ctl.beat),
    .stare     (ctl.stare),
    .emit_ok   (ctl.emit_ok),
    .sum       (sum),
    .sum_ovf   (sum_ovf),
    .sample    (pix_data),
    .stage     (cur_stage),
    .col       (cur_col),
    .out_valid (out_valid),
    .out_stare (out_stare),
    .out_col   (out_col),
    .out_row   (out_row),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
  );

endmodule

// File: rtl/tdi_accum_chk.sv
module tdi_accum_chk #(
  parameter int NSTAGE = 8,
  parameter int NCOL   = 4,
  parameter int IN_W   = 14,
  parameter int OUT_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      pix_valid,
  input logic                      pix_sol,
  input logic                      mode_sel,
  input logic [IN_W-1:0]           pix_data,
  input logic                      out_valid,
  input logic                      out_stare,
  input logic [$clog2(NCOL)-1:0]   out_col,
  input logic [$clog2(NSTAGE)-1:0] out_row,
  input logic [OUT_W-1:0]          out_data,
  input logic                      out_ovf
);

  localparam int CW = $clog2(NCOL);
  localparam int SW = $clog2(NSTAGE);

  logic          have_last_q;
  logic [CW-1:0] last_col_q;
  logic [CW-1:0] next_col;
  logic          tdi_word;

  assign tdi_word = out_valid && !out_stare;
  assign next_col = (last_col_q == CW'(NCOL - 1)) ? '0 : last_col_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last_q <= 1'b0;
      last_col_q  <= '0;
    end else if (tdi_word) begin
      have_last_q <= 1'b1;
      last_col_q  <= out_col;
    end
  end

  AST_SAT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf && out_valid |-> !out_stare && (out_data == {OUT_W{1'b1}})); // R3

  AST_STARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stare |-> (out_data == OUT_W'($past(pix_data))) && !out_ovf); // R6

  AST_WORD_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_valid)); // R8

  AST_COL_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    tdi_word && have_last_q |-> out_col == next_col); // R4

  AST_TDI_LAST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    tdi_word |-> out_row == SW'(NSTAGE - 1)); // R4

endmodule

bind tdi_accum tdi_accum_chk #(
  .NSTAGE (NSTAGE),
  .NCOL   (NCOL),
  .IN_W   (IN_W),
  .OUT_W  (OUT_W)
) u_chk (.*);

// File: tb/tdi_accum_tb.sv
module tdi_accum_tb;

  localparam int NSTAGE     = 8;
  localparam int NCOL       = 4;
  localparam int IN_W       = 14;
  localparam int OUT_W      = 16;
  localparam int CLK_PERIOD = 10;
  localparam int FULL       = (1 << OUT_W) - 1;
  localparam int HDEPTH     = 16;

  typedef struct packed {
    logic       mode;    // 0 integration, 1 staring
    logic [2:0] pat;
    logic [4:0] nlines;
    logic       glitch;  // toggle mode_sel on non-start beats
    logic       gaps;    // idle cycles inside the line
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 3'd1, 5'd10, 1'b0, 1'b0},
    '{1'b0, 3'd3, 5'd4,  1'b0, 1'b1},
    '{1'b1, 3'd1, 5'd2,  1'b0, 1'b0},
    '{1'b0, 3'd3, 5'd9,  1'b1, 1'b0},
    '{1'b0, 3'd4, 5'd9,  1'b0, 1'b0},
    '{1'b0, 3'd5, 5'd9,  1'b0, 1'b1},
    '{1'b1, 3'd2, 5'd1,  1'b1, 1'b0},
    '{1'b0, 3'd0, 5'd8,  1'b0, 1'b0}
  };

  logic                      clk;
  logic                      rst_n;
  logic                      pix_valid;
  logic                      pix_sol;
  logic                      mode_sel;
  logic [IN_W-1:0]           pix_data;
  logic                      out_valid;
  logic                      out_stare;
  logic [$clog2(NCOL)-1:0]   out_col;
  logic [$clog2(NSTAGE)-1:0] out_row;
  logic [OUT_W-1:0]          out_data;
  logic                      out_ovf;

  tdi_accum #(.NSTAGE(NSTAGE), .NCOL(NCOL), .IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_sol   (pix_sol),
    .mode_sel  (mode_sel),
    .pix_data  (pix_data),
    .out_valid (out_valid),
    .out_stare (out_stare),
    .out_col   (out_col),
    .out_row   (out_row),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_checks;
  int    n_errors;
  int    hist [HDEPTH][NCOL][NSTAGE];
  int    gl;
  int    tb_fill;
  logic  tb_mode;
  logic  tb_started;

  // Expectation for the word visible at the next falling edge
  logic  exp_valid, exp_stare, exp_ovf;
  int    exp_col, exp_row, exp_data;
  string exp_req;
  logic  nxt_valid, nxt_stare, nxt_ovf;
  int    nxt_col, nxt_row, nxt_data;
  string nxt_req;

  function automatic int samp(input int pat, input int line, input int c, input int s);
    case (pat)
      0: samp = 0;
      1: samp = (line * 13 + c * 7 + s * 3 + 1) & ((1 << IN_W) - 1);
      2: samp = (1 << IN_W) - 1;
      3: samp = ((line * 97 + c * 41 + s * 29) ^ (s << 9)) & ((1 << IN_W) - 1);
      4: samp = (s < NSTAGE - 1) ? 8192 : 8191;
      default: samp = 8192;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (line %0d)", req, what, act, expv, gl);
    end
  endtask

  task automatic check_out();
    check(exp_req, "out_valid", int'(out_valid), int'(exp_valid));
    if (exp_valid) begin
      check(exp_req, "out_data",  int'(out_data),  exp_data);
      check(exp_req, "out_ovf",   int'(out_ovf),   int'(exp_ovf));
      check(exp_req, "out_col",   int'(out_col),   exp_col);
      check(exp_req, "out_row",   int'(out_row),   exp_row);
      check(exp_req, "out_stare", int'(out_stare), int'(exp_stare));
    end
  endtask

  task automatic drive(input logic v, input logic sol, input logic m, input int d);
    @(negedge clk);
    check_out();
    pix_valid = v;
    pix_sol   = sol;
    mode_sel  = m;
    pix_data  = IN_W'(d);
    exp_valid = nxt_valid;
    exp_stare = nxt_stare;
    exp_ovf   = nxt_ovf;
    exp_col   = nxt_col;
    exp_row   = nxt_row;
    exp_data  = nxt_data;
    exp_req   = nxt_req;
  endtask

  task automatic idle(input string req);
    nxt_valid = 1'b0;
    nxt_req   = req;
    drive(1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic run_line(input vec_t v);
    int sum;
    if (!tb_started || (v.mode != tb_mode)) tb_fill = 0;
    else if (tb_fill < NSTAGE - 1) tb_fill++;
    tb_started = 1'b1;
    tb_mode    = v.mode;
    for (int c = 0; c < NCOL; c++) begin
      for (int s = 0; s < NSTAGE; s++) begin
        int d;
        logic sol;
        if (v.gaps && (s == 3)) idle("R8");
        d   = samp(int'(v.pat), gl, c, s);
        sol = (c == 0) && (s == 0);
        hist[gl % HDEPTH][c][s] = d;
        nxt_valid = 1'b0;
        nxt_req   = (tb_fill < NSTAGE - 1) ? "R5" : "R4";
        if (v.mode) begin
          nxt_valid = 1'b1; nxt_stare = 1'b1; nxt_ovf = 1'b0;
          nxt_col = c; nxt_row = s; nxt_data = d; nxt_req = "R6";
        end else if ((s == NSTAGE - 1) && (tb_fill == NSTAGE - 1)) begin
          sum = 0;
          for (int k = 0; k < NSTAGE; k++)
            sum += hist[(gl - (NSTAGE - 1) + k) % HDEPTH][c][k];
          nxt_valid = 1'b1; nxt_stare = 1'b0;
          nxt_ovf   = (sum > FULL);
          nxt_data  = (sum > FULL) ? FULL : sum;
          nxt_col = c; nxt_row = NSTAGE - 1;
          nxt_req = (sum >= FULL) ? "R3" : "R2";
        end
        if (v.glitch) nxt_req = "R7";
        drive(1'b1, sol, sol ? v.mode : (v.glitch ? ~v.mode : v.mode), d);
      end
    end
    gl++;
  endtask

  initial begin
    n_checks = 0; n_errors = 0; gl = 0; tb_fill = 0;
    tb_mode = 1'b0; tb_started = 1'b0;
    rst_n = 1'b0; pix_valid = 1'b0; pix_sol = 1'b0; mode_sel = 1'b0; pix_data = '0;
    exp_valid = 1'b0; exp_stare = 1'b0; exp_ovf = 1'b0;
    exp_col = 0; exp_row = 0; exp_data = 0; exp_req = "R8";
    nxt_valid = 1'b0; nxt_stare = 1'b0; nxt_ovf = 1'b0;
    nxt_col = 0; nxt_row = 0; nxt_data = 0; nxt_req = "R8";
    // R8: reset state
    repeat (3) begin
      @(negedge clk);
      check("R8", "reset out_valid", int'(out_valid), 0);
      check("R8", "reset out_ovf",   int'(out_ovf),   0);
      check("R8", "reset out_data",  int'(out_data),  0);
    end
    rst_n = 1'b1;
    // R1: beats before the first start-of-line are ignored
    nxt_valid = 1'b0; nxt_req = "R1";
    drive(1'b1, 1'b0, 1'b1, 77);
    drive(1'b1, 1'b0, 1'b1, 78);
    nxt_req = "R1";
    drive(1'b0, 1'b0, 1'b0, 0);
    for (int i = 0; i < NVEC; i++) begin
      for (int l = 0; l < int'(VECS[i].nlines); l++) run_line(VECS[i]);
    end
    idle("R8");
    idle("R8");
    @(negedge clk);
    check_out();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule